// File: doc/BRIEF.md
# Watchdog Timer with Service Clear

This block is a watchdog for a small controller. A dedicated watchdog clock drives a prescaler, and the prescaler advances a short counter. If software does not service the watchdog in time, the block pulls its active-low reset output low for a fixed number of clocks. It also sets a sticky flag, so that boot code can later find out why the chip restarted.

Software picks a long or a short timeout with one select bit. A service write clears the counter and the upper part of the prescaler. The lowest prescaler stages keep running, so each timeout is shortened by a small fixed margin. That margin keeps the timeouts off exact powers of two.

Several events restart the count:
- A stop-mode strobe clears the prescaler.
- A strobe from the power-on logic, raised once the oscillator has settled, also clears the prescaler.
- An internal chip reset clears both the prescaler and the counter.

A disable input suppresses the reset entirely. A read port returns a constant byte and has no effect on the timer.

Top module: `wdt_service_timer`

## Requirements
- R1: With `rate_sel`=0, `wdt_rst_n` falls exactly 2^(PRE_W+CNT_W) − 2^KEEP_W clocks after the clock edge that sampled a clearing event (262,128 with the defaults).
- R2: With `rate_sel`=1, the same interval is 2^(SHORT_W+CNT_W) − 2^KEEP_W clocks (8,176 with the defaults).
- R3: A `svc_wr` pulse zeroes the counter and prescaler bits [PRE_W−1:KEEP_W]. The low KEEP_W prescaler bits keep counting. The next reset therefore comes (timeout − ((low bits after the edge) mod 2^KEEP_W)) clocks later.
- R4: On overflow, `wdt_rst_n` stays low for exactly PULSE_LEN (32) clocks and `wdt_flag` becomes 1.
- R5: `wdt_flag` stays 1 until a `stat_clr` pulse, including through and after the block's own reset pulse.
- R6: While `wdt_rst_n` is low, the prescaler and counter are held at zero. The next timeout is measured from the edge at which `wdt_rst_n` rises.
- R7: A `stop_clr` pulse zeroes the whole prescaler and leaves the counter untouched.
- R8: An `int_rst` pulse zeroes both the prescaler and the counter.
- R9: A `por_clr` pulse zeroes the whole prescaler and leaves the counter untouched.
- R10: If `svc_wr` arrives in the same cycle as an overflow, no reset is issued and the flag is not set.
- R11: While `wdt_dis` is 1, overflow neither lowers `wdt_rst_n` nor sets `wdt_flag`.
- R12: `rd_data` always equals the parameter RD_VALUE (default 8'h3C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous register initialisation, active low |
| svc_wr | input | 1 | Service write strobe, one cycle |
| stop_clr | input | 1 | Stop-mode entry strobe |
| int_rst | input | 1 | Internal chip reset, clears all counting state |
| por_clr | input | 1 | Power-on settle strobe |
| rate_sel | input | 1 | 0 selects the long timeout, 1 the short one |
| wdt_dis | input | 1 | Suppresses reset generation |
| stat_clr | input | 1 | Clears the sticky reset flag |
| wdt_rst_n | output | 1 | Watchdog reset request, active low |
| wdt_flag | output | 1 | Sticky flag recording a watchdog reset |
| rd_data | output | 8 | Constant read value |

## Verification
The bench shrinks the counter widths so that full timeouts fit in a run. It then measures the exact clock count from each clearing event to the falling edge of the reset, in both rates. Service writes are placed at prescaler phases where the kept low bits are non-zero, which separates a partial clear from a full one. Stop and power-on strobes are issued with the counter already advanced, so keeping the counter can be told apart from clearing it. A service write in the exact overflow cycle and a run with the disable input held check that the reset is suppressed. Back-to-back pulses show that counting restarts at the pulse end, and the flag is checked before and after its clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        RATE_LONG  = 1'b0,
        RATE_SHORT = 1'b1
    } wdt_rate_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W   = 12,
    parameter int SHORT_W = 7,
    parameter int KEEP_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_all,
    input  logic                 clr_upper,
    input  wdt_pkg::wdt_rate_e   rate,
    output logic [PRE_W-1:0]     pre_o,
    output logic                 tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [KEEP_W-1:0] low_inc;

    always_comb begin
        st_d    = st_q;
        low_inc = st_q.pre[KEEP_W-1:0] + {{(KEEP_W-1){1'b0}}, 1'b1};
        if (clr_all) begin
            st_d.pre = '0;
        end else if (clr_upper) begin
            st_d.pre = '0;
            st_d.pre[KEEP_W-1:0] = low_inc;
        end else begin
            st_d.pre = st_q.pre + {{(PRE_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pre_o  = st_q.pre;
    assign tick_o = (rate == wdt_pkg::RATE_SHORT) ? (&st_q.pre[SHORT_W-1:0])
                                                  : (&st_q.pre);

    // R7 / R9: stop and power-on strobes leave the prescaler at zero
    a_r7_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (pre_o == '0));

    // R3: service zeroes the upper stages while the low stages advance
    a_r3_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_upper && !clr_all) |=>
            ((pre_o[PRE_W-1:KEEP_W] == '0) &&
             (pre_o[KEEP_W-1:0] == KEEP_W'($past(pre_o[KEEP_W-1:0]) + 1'b1))));
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout #(
    parameter int PRE_W   = 12,
    parameter int CNT_W   = 6,
    parameter int SHORT_W = 7,
    parameter int KEEP_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 tick,
    input  wdt_pkg::wdt_rate_e   rate,
    input  logic [PRE_W-1:0]     pre_i,
    output logic                 ovf_o
);
    localparam logic [PRE_W-1:0]   LONG_LAST  = PRE_W'((1 << PRE_W) - (1 << KEEP_W) - 1);
    localparam logic [SHORT_W-1:0] SHORT_LAST = SHORT_W'((1 << SHORT_W) - (1 << KEEP_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       pre_match;

    always_comb begin
        st_d = st_q;
        if (clr)       st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (rate == wdt_pkg::RATE_SHORT) pre_match = (pre_i[SHORT_W-1:0] == SHORT_LAST);
        else                             pre_match = (pre_i == LONG_LAST);
    end

    assign ovf_o = (&st_q.cnt) && pre_match;

    // R3 / R8: a clear leaves the counter at zero
    a_r8_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

    // R7: without clear or tick, the counter holds its value
    a_r7_cnt_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(st_q.cnt));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic stat_clr,
    output logic active_o,
    output logic flag_o
);
    localparam int LEN_W = $clog2(PULSE_LEN);

    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] left;
        logic             flag;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.left == '0) st_d.active = 1'b0;
            else                 st_d.left   = st_q.left - {{(LEN_W-1){1'b0}}, 1'b1};
        end else if (trig) begin
            st_d.active = 1'b1;
            st_d.left   = LEN_W'(PULSE_LEN - 1);
        end
        if (trig && !st_q.active) st_d.flag = 1'b1;
        else if (stat_clr)        st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign flag_o   = st_q.flag;

    // R4: each pulse is recorded in the flag
    a_r4_flag_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> flag_o);

    // R5: only a clear strobe removes the flag
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !stat_clr) |=> flag_o);
endmodule

// File: rtl/wdt_service_timer.sv
module wdt_service_timer #(
    parameter int         PRE_W     = 12,
    parameter int         CNT_W     = 6,
    parameter int         SHORT_W   = 7,
    parameter int         KEEP_W    = 4,
    parameter int         PULSE_LEN = 32,
    parameter logic [7:0] RD_VALUE  = 8'h3C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc_wr,
    input  logic       stop_clr,
    input  logic       int_rst,
    input  logic       por_clr,
    input  logic       rate_sel,
    input  logic       wdt_dis,
    input  logic       stat_clr,
    output logic       wdt_rst_n,
    output logic       wdt_flag,
    output logic [7:0] rd_data
);
    wdt_pkg::wdt_rate_e rate;
    logic [PRE_W-1:0]   pre;
    logic               tick, ovf, hold, trig;
    logic               pre_clr_all, cnt_clr;

    assign rate        = wdt_pkg::wdt_rate_e'(rate_sel);
    assign pre_clr_all = int_rst | stop_clr | por_clr | hold;
    assign cnt_clr     = int_rst | svc_wr | hold;
    assign trig        = ovf & ~svc_wr & ~wdt_dis;

    wdt_prescaler #(.PRE_W(PRE_W), .SHORT_W(SHORT_W), .KEEP_W(KEEP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr_all(pre_clr_all), .clr_upper(svc_wr),
        .rate(rate), .pre_o(pre), .tick_o(tick)
    );

    wdt_timeout #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SHORT_W(SHORT_W), .KEEP_W(KEEP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick), .rate(rate),
        .pre_i(pre), .ovf_o(ovf)
    );

    wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trig(trig), .stat_clr(stat_clr),
        .active_o(hold), .flag_o(wdt_flag)
    );

    assign wdt_rst_n = ~hold;
    assign rd_data   = RD_VALUE;

    // R10: a service write in the overflow cycle keeps the reset high
    a_r10_svc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && wdt_rst_n) |=> wdt_rst_n);

    // R11: the disable input keeps the reset high
    a_r11_dis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_dis && wdt_rst_n) |=> wdt_rst_n);

    // R6: counting restarts from zero once the pulse ends
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_n) |-> (pre == '0));
endmodule

// File: tb/wdt_service_timer_bench.sv
module wdt_service_timer_bench;
    localparam int PRE_W = 8, CNT_W = 4, SHORT_W = 5, KEEP_W = 4, PULSE = 32;
    localparam int TL    = (1 << (PRE_W + CNT_W)) - (1 << KEEP_W);
    localparam int TS    = (1 << (SHORT_W + CNT_W)) - (1 << KEEP_W);
    localparam int PRE_N = 1 << PRE_W;
    localparam int LOW_M = (1 << KEEP_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic svc_wr = 0, stop_clr = 0, int_rst = 0, por_clr = 0;
    logic rate_sel = 0, wdt_dis = 0, stat_clr = 0;
    logic wdt_rst_n, wdt_flag;
    logic [7:0] rd_data;

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    int exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_service_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SHORT_W(SHORT_W),
                        .KEEP_W(KEEP_W), .PULSE_LEN(PULSE)) u_wdt_service_timer (
        .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .stop_clr(stop_clr),
        .int_rst(int_rst), .por_clr(por_clr), .rate_sel(rate_sel),
        .wdt_dis(wdt_dis), .stat_clr(stat_clr), .wdt_rst_n(wdt_rst_n),
        .wdt_flag(wdt_flag), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_fall(input int at, input string tag);
        exp_q.push_back(at);
        tag_q.push_back(tag);
    endtask

    // code: 0 service, 1 stop, 2 internal reset, 3 power-on, 4 flag clear
    task automatic hit(input int code, input int at, output int c);
        @(negedge clk);
        while (cyc < at) @(negedge clk);
        case (code)
            0: svc_wr = 1;  1: stop_clr = 1; 2: int_rst = 1;
            3: por_clr = 1; default: stat_clr = 1;
        endcase
        c = cyc;
        @(negedge clk);
        svc_wr = 0; stop_clr = 0; int_rst = 0; por_clr = 0; stat_clr = 0;
    endtask

    task automatic wait_to(input int at);
        while (cyc < at) @(negedge clk);
    endtask

    task automatic drain(input int limit, input string tag);
        for (int k = 0; k < limit; k++) begin
            if (exp_q.size() == 0 && wdt_rst_n) break;
            @(negedge clk);
        end
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // monitor: pops each expected fall time and compares
    logic prev_rst = 1'b1;
    int fall_at = 0;
    always @(negedge clk) begin
        int e;
        string t;
        if (rst_n) begin
            if (prev_rst && !wdt_rst_n) begin
                if (exp_q.size() == 0) begin
                    check(0, "R10/R11 unexpected reset", cyc, -1);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(cyc == e, t, cyc, e);
                end
                fall_at = cyc;
            end
            if (!prev_rst && wdt_rst_n)
                check(cyc - fall_at == PULSE, "R4 pulse width", cyc - fall_at, PULSE);
            prev_rst = wdt_rst_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", cyc, -1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c, e, n;
        repeat (3) @(negedge clk);
        check(wdt_rst_n == 1'b1, "R4 reset-state output high", wdt_rst_n, 1);
        check(wdt_flag == 1'b0, "R5 reset-state flag clear", wdt_flag, 0);
        check(rd_data == 8'h3C, "R12 read value", rd_data, 8'h3C);
        rst_n = 1'b1;

        // R1, R8, R6: long timeout from an internal reset, then restart
        hit(2, 0, c); e = c + 1;
        expect_fall(e + TL, "R1 long timeout after R8 clear");
        expect_fall(e + TL + PULSE + TL, "R6 restart after pulse");
        wait_to(e + TL + 5);
        check(wdt_flag == 1'b1, "R4 flag set", wdt_flag, 1);
        wait_to(e + TL + PULSE + 10);
        check(wdt_flag == 1'b1, "R5 flag kept after own pulse", wdt_flag, 1);
        drain(3 * TL, "R6 all resets seen");
        check(wdt_flag == 1'b1, "R5 flag kept", wdt_flag, 1);
        hit(4, 0, c);
        check(wdt_flag == 1'b0, "R5 flag cleared", wdt_flag, 0);
        check(rd_data == 8'h3C, "R12 read value after reset", rd_data, 8'h3C);

        // R2: short timeout
        rate_sel = 1;
        hit(2, 0, c);
        expect_fall(c + 1 + TS, "R2 short timeout");
        drain(2 * TS, "R2 short reset seen");
        rate_sel = 0;

        // R3: two services at non-zero low phases
        hit(2, 0, c); e = c + 1;
        hit(0, e + 3003, c);
        hit(0, c + 1707, c);
        expect_fall(c + 1 + TL - ((c + 1 - e) & LOW_M), "R3 service keeps low stages");
        drain(2 * TL, "R3 reset seen");

        // R7: stop clears prescaler, keeps counter
        hit(2, 0, c); e = c + 1;
        hit(1, e + 2 * PRE_N + 10, c); n = c - e;
        expect_fall(c + 1 + TL - PRE_N * (n / PRE_N), "R7 stop keeps counter");
        drain(2 * TL, "R7 reset seen");

        // R9: power-on strobe clears prescaler, keeps counter
        hit(2, 0, c); e = c + 1;
        hit(3, e + PRE_N + 44, c); n = c - e;
        expect_fall(c + 1 + TL - PRE_N * (n / PRE_N), "R9 power-on keeps counter");
        drain(2 * TL, "R9 reset seen");

        // R10: service in the exact overflow cycle
        hit(4, 0, c);
        hit(2, 0, c); e = c + 1;
        hit(0, e + TL - 1, c);
        expect_fall(c + 1 + TL - ((c + 1 - e) & LOW_M), "R10 next timeout after late service");
        wait_to(e + TL + 5);
        check(wdt_rst_n == 1'b1, "R10 no reset on tie", wdt_rst_n, 1);
        check(wdt_flag == 1'b0, "R10 flag not set on tie", wdt_flag, 0);
        drain(2 * TL, "R10 reset seen");

        // R11: disable suppresses reset and flag
        hit(4, 0, c);
        wdt_dis = 1;
        hit(2, 0, c); e = c + 1;
        wait_to(e + TL + 50);
        check(wdt_rst_n == 1'b1, "R11 disabled output high", wdt_rst_n, 1);
        check(wdt_flag == 1'b0, "R11 disabled flag clear", wdt_flag, 0);
        wdt_dis = 0;
        hit(2, 0, c);
        expect_fall(c + 1 + TL, "R11 normal after enable (R8)");
        drain(2 * TL, "R11 reset seen");

        check(exp_q.size() == 0, "R1 scoreboard empty", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule